// File: doc/BRIEF.md
# Programmable-Priority DMA Channel Arbiter

This block decides which of eight DMA channels owns a shared bus master. Each channel raises a request line and supplies a three-bit urgency level. When arbitration takes place, the requesting channel with the numerically smallest level wins. Among channels with equal levels, the lowest channel number wins. If every level is left at zero, this reduces to fixed order by channel number.

The winner is given a registered one-hot grant and its encoded index. The grant stays with that channel until a completion strobe arrives or the channel withdraws its request. Arbitration happens only at those moments, or while nothing is granted. A level that changes during a grant therefore matters only from the next arbitration onward. There is no combinational path from any request to the grant.

Top module: `dma_chan_arb`

## Requirements
- R1: `grant` never has more than one bit set. It is all zeros in the cycle after an arbitration that saw no request.
- R2: At arbitration, the granted channel is a requesting channel whose level is less than or equal to every other requester's level. Channel i's level is `prio[3*i+2:3*i]`, and 0 is the most urgent.
- R3: When requesters share the winning level, the lowest-numbered one is granted. With all levels equal, the grant follows fixed channel-number order.
- R4: While `rst_n` is low, `grant` is zero and `grant_idx` is zero.
- R5: A grant appears on the first rising edge after the request is sampled. Changing `req` between edges does not change `grant` before the next edge.
- R6: While the granted channel keeps its request and `done` is low, the grant is held. This holds even if a more urgent channel starts requesting.
- R7: When `done` is high at an edge, the block re-arbitrates at that edge. All current requesters are considered, including the channel that was just granted.
- R8: If the granted channel drops its request, the block re-arbitrates at the next edge.
- R9: A change to a level during a grant does not affect the grant until the next arbitration.
- R10: `grant_idx` holds the index of the set `grant` bit. It is 0 when no grant is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 8 | Request line per channel |
| prio | input | 24 | Per-channel 3-bit level; channel i at bits 3i+2..3i |
| done | input | 1 | Current transaction complete strobe |
| grant | output | 8 | One-hot grant, registered |
| grant_idx | output | 3 | Encoded index of the granted channel |

## Verification
Directed sequences separate the ordering rules from one another:

- All levels at zero shows pure index order.
- Distinct levels show that urgency overrides index.
- Partial level ties show that the index only breaks ties.

Further directed cases show that a more urgent late arrival does not preempt a held grant, and that level rewrites during a grant are deferred. They also cover re-arbitration on `done` and on request withdrawal. A few thousand random cycles of requests, levels and `done` strobes then compare every grant against a bench model of the selection rule.

// File: rtl/dma_chan_arb.sv
module dma_chan_arb #(
  parameter int NCH = 8,
  parameter int PW  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         req,
  input  logic [NCH*PW-1:0]      prio,
  input  logic                   done,
  output logic [NCH-1:0]         grant,
  output logic [$clog2(NCH)-1:0] grant_idx
);
  localparam int IW = $clog2(NCH);

  logic          win_found;
  logic [IW-1:0] win_idx;
  logic [PW-1:0] win_lvl;

  always_comb begin
    win_found = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i] && (!win_found || prio[i*PW +: PW] <= win_lvl)) begin
        win_found = 1'b1;
        win_idx   = IW'(i);
        win_lvl   = prio[i*PW +: PW];
      end
    end
  end

  logic holder_req, rearb;
  assign holder_req = |(req & grant);
  assign rearb      = !holder_req || done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant     <= '0;
      grant_idx <= '0;
    end else if (rearb) begin
      grant     <= win_found ? (NCH'(1) << win_idx) : '0;
      grant_idx <= win_found ? win_idx : '0;
    end
  end

  // R1
  onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (grant == '0));

  // R5
  grant_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> (($past(req) & grant) != '0));

  // R6
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((req & grant) != '0) && !done) |=> (grant == $past(grant)));

  // R10
  idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) ? (grant_idx == '0) : (grant[grant_idx] == 1'b1));
endmodule

// File: tb/dma_chan_arb_tb.sv
module dma_chan_arb_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  req;
  logic [23:0] prio;
  logic        done;
  logic [7:0]  grant;
  logic [2:0]  grant_idx;

  int checks = 0;
  int errors = 0;
  int exp_g  = -1;

  always #4 clk = ~clk;

  dma_chan_arb u_dut (.clk(clk), .rst_n(rst_n), .req(req), .prio(prio),
                      .done(done), .grant(grant), .grant_idx(grant_idx));

  function automatic int pick(input logic [7:0] r, input logic [23:0] p);
    int best = -1;
    for (int i = 0; i < 8; i++)
      if (r[i] && (best < 0 || p[i*3 +: 3] < p[best*3 +: 3])) best = i;
    return best;
  endfunction

  task automatic chk(input string tag);
    logic [7:0] eg = (exp_g < 0) ? 8'h00 : (8'h01 << exp_g);
    logic [2:0] ei = (exp_g < 0) ? 3'd0 : 3'(exp_g);
    checks++;
    if (grant !== eg || grant_idx !== ei) begin
      errors++;
      $display("FAIL %s grant=%b idx=%0d expected grant=%b idx=%0d", tag, grant, grant_idx, eg, ei);
    end
  endtask

  task automatic step(input logic [7:0] r, input logic [23:0] p, input logic d, input string tag);
    @(negedge clk);
    req = r; prio = p; done = d;
    if (exp_g < 0 || d || !r[exp_g]) exp_g = pick(r, p);
    @(posedge clk); #1;
    chk(tag);
  endtask

  function automatic logic [23:0] lv(input int ch, input int v, input logic [23:0] base);
    logic [23:0] t = base;
    t[ch*3 +: 3] = 3'(v);
    return t;
  endfunction

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] p;
    void'($urandom(32'd1234));
    rst_n = 1'b0; req = 8'hFF; prio = '0; done = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    exp_g = -1;
    chk("R4");
    @(negedge clk);
    rst_n = 1'b1; req = '0;
    @(posedge clk); #1;
    chk("R1");

    // R5: no combinational path
    @(negedge clk);
    req = 8'h10;
    #1;
    chk("R5");
    exp_g = 4;
    @(posedge clk); #1;
    chk("R5");
    step(8'h00, '0, 1'b0, "R8");
    step(8'h00, '0, 1'b0, "R1");

    // R3: all levels zero
    step(8'hF0, '0, 1'b0, "R3");
    step(8'hF0, '0, 1'b1, "R3");
    step(8'hE0, '0, 1'b0, "R8");
    step(8'h14, '0, 1'b1, "R3");

    // R2: level overrides index
    p = lv(0, 6, lv(3, 1, lv(7, 0, 24'o77777777)));
    step(8'h00, p, 1'b0, "R1");
    step(8'h89, p, 1'b0, "R2");
    step(8'h09, p, 1'b1, "R2");
    step(8'h01, p, 1'b1, "R2");
    step(8'h00, p, 1'b0, "R1");
    // R3 partial tie
    p = lv(2, 3, lv(4, 3, lv(6, 5, '0)));
    step(8'h54, p, 1'b0, "R3");

    // R6: no preemption by more urgent arrival
    p = lv(5, 0, 24'o77777777);
    step(8'h00, p, 1'b0, "R1");
    step(8'h02, p, 1'b0, "R6");
    step(8'h22, p, 1'b0, "R6");
    step(8'h22, p, 1'b0, "R6");
    step(8'h22, p, 1'b1, "R7");

    // R9: level rewrite during grant deferred
    p = lv(1, 0, 24'o77777777);
    step(8'h00, p, 1'b0, "R1");
    step(8'h42, p, 1'b0, "R9");
    p = lv(6, 0, lv(1, 7, 24'o77777777));
    step(8'h42, p, 1'b0, "R9");
    step(8'h42, p, 1'b1, "R9");
    // R7: holder re-wins on done when still best
    step(8'h42, p, 1'b1, "R7");

    // random
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] r = 8'($urandom);
      if ($urandom_range(0, 3) == 0) r = '0;
      if ($urandom_range(0, 4) == 0) p = 24'($urandom);
      if ($urandom_range(0, 6) == 0) p = '0;
      step(r, p, ($urandom_range(0, 2) == 0), "R2");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule